// File: doc/BRIEF.md
# Four-Bit Lookahead Adder Group

This block is a purely combinational adder slice for two 4-bit operands plus an incoming carry. It first forms, for every bit position, a generate term (both operand bits set) and a propagate term (the operand bits differ). Each internal carry is then produced directly from those terms and the carry-in by a flattened two-level AND-OR expression. No carry waits on the carry of the position below it. Each sum bit is the propagate term of its position XORed with the carry entering that position.

The slice also exports two group-level signals for a lookahead unit one level up.
- Group generate means the slice produces a carry-out by itself, whatever its carry-in.
- Group propagate means an incoming carry would travel through all four positions to the carry-out.

Subtraction needs no extra logic. The caller inverts the second operand and holds the carry-in at 1, and the outputs then give the two's-complement difference. The block has no clock, no reset and no state. It therefore has no states or transitions to list, and its outputs follow its inputs within the same evaluation.

Top module: `cla4_group`

## Requirements
- R1: `sum_out` equals (`a_op` + `b_op` + `c_in`) modulo 16, with both operands read as unsigned values.
- R2: `c_out` is 1 exactly when `a_op` + `b_op` + `c_in` is 16 or more.
- R3: `grp_gen` is 1 exactly when `a_op` + `b_op` is 16 or more, which is when a carry leaves the group with `c_in` at 0.
- R4: `grp_prop` is 1 exactly when `a_op` XOR `b_op` equals 4'b1111, so that every position passes an incoming carry along.
- R5: `c_out` always equals `grp_gen` OR (`grp_prop` AND `c_in`).
- R6: `grp_gen` and `grp_prop` are never 1 at the same time.
- R7: With `c_in` = 1 and `b_op` = ~d, `sum_out` equals (`a_op` − d) modulo 16, and `c_out` is 1 exactly when `a_op` ≥ d. For example, 0101 minus 0010 yields 0011 with `c_out` = 1.
- R8: All outputs settle from the present inputs alone, with no clock and no stored state. Applying the same inputs again gives the same outputs, whatever inputs came before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_op | input | 4 | First operand |
| b_op | input | 4 | Second operand |
| c_in | input | 1 | Carry into bit 0 |
| sum_out | output | 4 | Sum bits |
| c_out | output | 1 | Carry out of bit 3 |
| grp_gen | output | 1 | Group generate |
| grp_prop | output | 1 | Group propagate |

## Verification
The bench drives all 512 input combinations and compares every output against plain integer arithmetic. This catches the following faults:
- A carry term dropped from the flattened expansion: a sum would then go wrong only on the longest chains, such as 1111 + 0001 with carry-in 0, or 1111 + 0000 with carry-in 1.
- Group generate built with a carry-in term: this shows up as a mismatch when the carry-in is set and the operands sum to exactly 15.
- Group propagate built as an OR instead of an AND: this makes it rise on partial propagation.
- A swapped sense in the carry-out: the all-propagate operand pairs expose it.

A subtraction sweep then checks the difference and the borrow-free flag on every pair, including equal operands, where the carry-out must be 1. A second sweep in the reverse order repeats the inputs with different history, so any hidden state would be visible.

// File: rtl/cla_pkg.sv
package cla_pkg;
    localparam int GROUP_W = 4;
endpackage

// File: rtl/cla_bit_gp.sv
module cla_bit_gp #(
    parameter int W = 4
) (
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] y_in,
    output logic [W-1:0] gen_o,
    output logic [W-1:0] prop_o
);
    for (genvar k = 0; k < W; k++) begin : g_bit
        assign gen_o[k]  = x_in[k] & y_in[k];
        assign prop_o[k] = x_in[k] ^ y_in[k];
    end
endmodule

// File: rtl/cla_carry_net.sv
module cla_carry_net #(
    parameter int W = 4
) (
    input  logic [W-1:0] gen_i,
    input  logic [W-1:0] prop_i,
    input  logic         c0_i,
    output logic [W:0]   carry_o,
    output logic         grp_gen_o
);
    logic [W-1:0] gen_chain;

    assign carry_o[0] = c0_i;

    for (genvar i = 0; i < W; i++) begin : g_carry
        logic [i:0] terms;
        logic       cin_term;
        for (genvar j = 0; j <= i; j++) begin : g_term
            if (j == i) begin : g_top
                assign terms[j] = gen_i[j];
            end else begin : g_low
                assign terms[j] = gen_i[j] & (&prop_i[i:j+1]);
            end
        end
        assign cin_term     = c0_i & (&prop_i[i:0]);
        assign gen_chain[i] = |terms;
        assign carry_o[i+1] = gen_chain[i] | cin_term;
    end

    assign grp_gen_o = gen_chain[W-1];
endmodule

// File: rtl/cla_sum_stage.sv
module cla_sum_stage #(
    parameter int W = 4
) (
    input  logic [W-1:0] prop_i,
    input  logic [W-1:0] carry_i,
    output logic [W-1:0] sum_o
);
    for (genvar k = 0; k < W; k++) begin : g_sum
        assign sum_o[k] = prop_i[k] ^ carry_i[k];
    end
endmodule

// File: rtl/cla4_group.sv
module cla4_group
    import cla_pkg::*;
#(
    parameter int W = GROUP_W
) (
    input  logic [W-1:0] a_op,
    input  logic [W-1:0] b_op,
    input  logic         c_in,
    output logic [W-1:0] sum_out,
    output logic         c_out,
    output logic         grp_gen,
    output logic         grp_prop
);
    logic [W-1:0] bit_gen;
    logic [W-1:0] bit_prop;
    logic [W:0]   carries;

    cla_bit_gp #(.W(W)) u_gp (
        .x_in   (a_op),
        .y_in   (b_op),
        .gen_o  (bit_gen),
        .prop_o (bit_prop)
    );

    cla_carry_net #(.W(W)) u_carry (
        .gen_i     (bit_gen),
        .prop_i    (bit_prop),
        .c0_i      (c_in),
        .carry_o   (carries),
        .grp_gen_o (grp_gen)
    );

    cla_sum_stage #(.W(W)) u_sum (
        .prop_i  (bit_prop),
        .carry_i (carries[W-1:0]),
        .sum_o   (sum_out)
    );

    assign c_out    = carries[W];
    assign grp_prop = &bit_prop;
endmodule

// File: rtl/cla4_group_chk.sv
module cla4_group_chk #(
    parameter int W = 4
) (
    input logic [W-1:0] a_op,
    input logic [W-1:0] b_op,
    input logic         c_in,
    input logic [W-1:0] sum_out,
    input logic         c_out,
    input logic         grp_gen,
    input logic         grp_prop
);
    logic [W:0] ref_total;
    assign ref_total = {1'b0, a_op} + {1'b0, b_op} + {{W{1'b0}}, c_in};

    always_comb begin
        // R1
        sum_match_chk: assert (sum_out == ref_total[W-1:0]);
        // R2
        carry_match_chk: assert (c_out == ref_total[W]);
        // R4
        prop_all_chk: assert (grp_prop == ((a_op ^ b_op) == {W{1'b1}}));
        // R5
        carry_compose_chk: assert (c_out == (grp_gen | (grp_prop & c_in)));
        // R6
        gen_prop_excl_chk: assert (!(grp_gen && grp_prop));
    end
endmodule

bind cla4_group cla4_group_chk #(.W(W)) u_chk (
    .a_op     (a_op),
    .b_op     (b_op),
    .c_in     (c_in),
    .sum_out  (sum_out),
    .c_out    (c_out),
    .grp_gen  (grp_gen),
    .grp_prop (grp_prop)
);

// File: tb/cla4_group_test.sv
module cla4_group_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic [3:0] a_op = '0;
    logic [3:0] b_op = '0;
    logic       c_in = 1'b0;
    logic [3:0] sum_out;
    logic       c_out;
    logic       grp_gen;
    logic       grp_prop;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cla4_group uut (
        .a_op     (a_op),
        .b_op     (b_op),
        .c_in     (c_in),
        .sum_out  (sum_out),
        .c_out    (c_out),
        .grp_gen  (grp_gen),
        .grp_prop (grp_prop)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s a=%0d b=%0d cin=%0d actual=%0d expected=%0d",
                     req, a_op, b_op, c_in, act, exp);
        end
    endtask

    task automatic apply(input int a, input int b, input int ci);
        @(negedge clk);
        a_op = a[3:0];
        b_op = b[3:0];
        c_in = ci[0];
        #1;
    endtask

    task automatic check_add(input int a, input int b, input int ci);
        int total;
        apply(a, b, ci);
        total = a + b + ci;
        check("R1 sum", int'(sum_out), total % 16);
        check("R2 carry", int'(c_out), (total >= 16) ? 1 : 0);
        check("R3 group gen", int'(grp_gen), (a + b >= 16) ? 1 : 0);
        check("R4 group prop", int'(grp_prop), ((a ^ b) == 15) ? 1 : 0);
        check("R5 compose", int'(c_out),
              int'(grp_gen) | (int'(grp_prop) & ci));
        check("R6 exclusive", int'(grp_gen & grp_prop), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        $display("FAIL watchdog expired");
        errors++;
        checks++;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R8: no reset exists; the first inputs alone define the outputs
        apply(0, 0, 0);
        check("R8 initial sum", int'(sum_out), 0);
        check("R8 initial carry", int'(c_out), 0);

        // R1..R6 exhaustive, ascending order
        for (int ci = 0; ci < 2; ci++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    check_add(a, b, ci);

        // R7 subtraction by inverted operand and forced carry
        apply(5, (~2) & 15, 1);
        check("R7 example diff", int'(sum_out), 3);
        check("R7 example carry", int'(c_out), 1);
        for (int a = 0; a < 16; a++)
            for (int d = 0; d < 16; d++) begin
                apply(a, (~d) & 15, 1);
                check("R7 diff", int'(sum_out), (a - d + 16) % 16);
                check("R7 no borrow", int'(c_out), (a >= d) ? 1 : 0);
            end

        // R8 repeat in reverse order: different history, same results
        for (int ci = 1; ci >= 0; ci--)
            for (int a = 15; a >= 0; a--)
                for (int b = 15; b >= 0; b--)
                    check_add(a, b, ci);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule